// File: doc/BRIEF.md
# Microsecond Preloadable Interval Timer

This block is an 8-bit down-counter that produces a periodic interrupt request at an interval chosen in whole microseconds. A divide-by-four prescaler turns the 4 MHz system clock into a one-cycle tick every microsecond. The counter steps down on each tick. When it wraps, it reloads from a software-held preload value and raises a sticky level interrupt.

Software uses a small byte-wide write bus with three registers. The first holds the preload value and cannot be read back. The second is a one-bit run control. The third is a strobe: writing it with bit 0 set acknowledges the interrupt. A preload value N gives a period of N µs, and 0 gives 256 µs. An optional debug output shows the live count.

Top module: `usec_timer`

## Requirements
- R1: After reset the interrupt request is 0, the count is 0, the timer is stopped and the preload value is 0.
- R2: Address 0 takes the preload byte. Address 1 bit 0 is the run control (1 = run). Address 2 bit 0 = 1 clears the interrupt. The other bits at addresses 1 and 2, and any write to address 3, have no effect.
- R3: While running, the count changes once every 4 clock cycles. Its first change comes 4 cycles after the clock edge that sets the run control from 0 to 1, because the prescaler restarts there.
- R4: Take a count loaded with N and the run control set at edge W. The interrupt rises at edge W+4N, and N = 0 acts as 256 (edge W+1024).
- R5: When a tick finds the count at 1, the count reloads from the current preload value at the same edge and the interrupt flag is set.
- R6: The interrupt stays set until an acknowledge write with bit 0 = 1. It then reads 0 after that edge, unless a new wrap happens at the same edge.
- R7: If a wrap and an acknowledge fall on the same edge, the interrupt stays set.
- R8: A preload write while running leaves the current period unchanged and is used at the next reload. A preload write while stopped also loads the count at once.
- R9: While stopped, the count holds, no new interrupt is raised, and a pending interrupt stays set.
- R10: With the debug view enabled (default), the debug output equals the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 2 | Register select: 0 preload, 1 run control, 2 acknowledge, 3 unused |
| wr_data | input | DATA_W | Write data byte |
| irq | output | 1 | Level interrupt request |
| count_dbg | output | DATA_W | Live count (0 when the debug view is disabled) |

## Verification
On every cycle the assertions check four things. Ticks are never back to back and occur only while running. The flag stays set unless it is acknowledged, and an acknowledge with no tick drops it. A wrap always sets the flag and reloads the preload value. A stopped count stays still unless a preload write is made, and no interrupt rises while stopped. Only the bench's scenarios can show the absolute timing: that the first period lasts exactly 4N cycles from the run edge, that 0 gives 1024 cycles, that a preload change made during a period waits for the next reload, and that the ignored bits really do nothing.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_PRELOAD = 2'd0,
    ADR_RUN     = 2'd1,
    ADR_ACK     = 2'd2,
    ADR_SPARE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/uit_prescaler.sv
module uit_prescaler #(
  parameter int unsigned PRESCALE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] phase_q, phase_d;

  always_comb begin
    tick    = run && (phase_q == LAST);
    phase_d = phase_q;
    if (!run) begin
      phase_d = '0;
    end else if (phase_q == LAST) begin
      phase_d = '0;
    end else begin
      phase_d = phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end
endmodule

// File: rtl/uit_regs.sv
module uit_regs
  import usec_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] preload_q,
  output logic              run_q,
  output logic              preload_wr,
  output logic              ack_wr
);
  reg_addr_e   sel;
  logic [DATA_W-1:0] preload_d;
  logic        run_d;
  logic        run_wr;

  always_comb begin
    sel        = reg_addr_e'(wr_addr);
    preload_wr = wr_en && (sel == ADR_PRELOAD);
    run_wr     = wr_en && (sel == ADR_RUN);
    ack_wr     = wr_en && (sel == ADR_ACK) && wr_data[0];
    preload_d  = preload_wr ? wr_data : preload_q;
    run_d      = run_wr ? wr_data[0] : run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preload_q <= '0;
      run_q     <= 1'b0;
    end else begin
      preload_q <= preload_d;
      run_q     <= run_d;
    end
  end
endmodule

// File: rtl/uit_downcount.sv
module uit_downcount #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_val,
  input  logic [DATA_W-1:0] preload,
  output logic [DATA_W-1:0] cnt_q,
  output logic              wrap
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] cnt_d;

  always_comb begin
    wrap  = tick && (cnt_q == ONE);
    cnt_d = cnt_q;
    if (load_en) begin
      cnt_d = load_val;
    end else if (wrap) begin
      cnt_d = preload;
    end else if (tick) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/uit_irq_flag.sv
module uit_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag_q
);
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set) begin
      flag_d = 1'b1;
    end else if (clr) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/usec_timer.sv
module usec_timer
  import usec_timer_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PRESCALE = 4,
  parameter bit          DBG_EN   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq,
  output logic [DATA_W-1:0] count_dbg
);
  logic [1:0]        rst_sync_q;
  logic              rst_q_n;
  logic [DATA_W-1:0] preload_q;
  logic              run_q;
  logic              preload_wr;
  logic              ack_wr;
  logic              tick;
  logic              wrap;
  logic              load_en;
  logic [DATA_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_q_n = rst_sync_q[1];

  uit_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .preload_q  (preload_q),
    .run_q      (run_q),
    .preload_wr (preload_wr),
    .ack_wr     (ack_wr)
  );

  uit_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk   (clk),
    .rst_n (rst_q_n),
    .run   (run_q),
    .tick  (tick)
  );

  assign load_en = preload_wr && !run_q;

  uit_downcount #(.DATA_W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .tick     (tick),
    .load_en  (load_en),
    .load_val (wr_data),
    .preload  (preload_q),
    .cnt_q    (cnt_q),
    .wrap     (wrap)
  );

  uit_irq_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .set    (wrap),
    .clr    (ack_wr),
    .flag_q (irq)
  );

  generate
    if (DBG_EN) begin : g_dbg
      assign count_dbg = cnt_q;
    end else begin : g_nodbg
      assign count_dbg = '0;
    end
  endgenerate
endmodule

// File: rtl/usec_timer_chk.sv
module usec_timer_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              tick,
  input logic              run_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] preload_q,
  input logic              irq
);
  logic ack_seen;
  logic pre_seen;
  logic at_one;

  assign ack_seen = wr_en && (wr_addr == 2'd2) && wr_data[0];
  assign pre_seen = wr_en && (wr_addr == 2'd0);
  assign at_one   = tick && (cnt_q == DATA_W'(1));

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_q_n)
    tick |=> !tick); // R3
  AST_TICK_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_q_n)
    tick |-> run_q); // R3
  AST_WRAP_RELOADS: assert property (@(posedge clk) disable iff (!rst_q_n)
    at_one |=> (cnt_q == $past(preload_q))); // R5
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_q_n)
    (irq && !ack_seen) |=> irq); // R6
  AST_IRQ_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ack_seen && !tick) |=> !irq); // R6
  AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_q_n)
    at_one |=> irq); // R7
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!run_q && !pre_seen) |=> $stable(cnt_q)); // R9
  AST_STOPPED_NO_RISE: assert property (@(posedge clk) disable iff (!rst_q_n)
    !run_q |=> !$rose(irq)); // R9
endmodule

bind usec_timer usec_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .tick      (tick),
  .run_q     (run_q),
  .cnt_q     (cnt_q),
  .preload_q (preload_q),
  .irq       (irq)
);

// File: tb/usec_timer_test.sv
`timescale 1ns/1ps
module usec_timer_test;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       irq;
  logic [7:0] count_dbg;

  int errors;
  int checks;
  int cyc;
  int edge_w;

  usec_timer uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .irq       (irq),
    .count_dbg (count_dbg)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Called at a negedge; the write lands on the next edge, whose number is returned in edge_w.
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = 8'h00;
    wr_addr = 2'd3;
    edge_w  = cyc;
  endtask

  task automatic goto(input int e);
    while (cyc < e) @(negedge clk);
  endtask

  task automatic wr_at(input int e, input logic [1:0] a, input logic [7:0] d);
    goto(e - 1);
    wr(a, d);
  endtask

  task automatic t_reset;
    chk("R1", "irq", irq, 0);
    chk("R1", "count", count_dbg, 0);
    repeat (20) @(negedge clk);
    chk("R1", "stopped count", count_dbg, 0);
    chk("R1", "stopped irq", irq, 0);
  endtask

  task automatic t_load_stopped;
    wr(2'd0, 8'd5);
    chk("R8", "load while stopped", count_dbg, 5);
    chk("R10", "debug view", count_dbg, 5);
    wr(2'd3, 8'd9);
    chk("R2", "spare address ignored", count_dbg, 5);
  endtask

  task automatic t_basic_period;
    int w;
    wr(2'd1, 8'h01);
    w = edge_w;
    goto(w + 3);
    chk("R3", "no step before 4 cycles", count_dbg, 5);
    goto(w + 4);
    chk("R3", "first step", count_dbg, 4);
    goto(w + 19);
    chk("R4", "irq before period", irq, 0);
    goto(w + 20);
    chk("R4", "irq at 4N", irq, 1);
    chk("R5", "reload on wrap", count_dbg, 5);
    goto(w + 40);
    chk("R6", "sticky over periods", irq, 1);
    wr_at(w + 42, 2'd2, 8'hFE);
    chk("R2", "ack bit0=0 ignored", irq, 1);
    wr_at(w + 44, 2'd2, 8'h01);
    chk("R6", "ack clears", irq, 0);
    chk("R3", "count at W+44", count_dbg, 4);
    wr_at(w + 46, 2'd1, 8'hFE);
    repeat (100) @(negedge clk);
    chk("R9", "count holds stopped", count_dbg, 4);
    chk("R9", "no irq stopped", irq, 0);
  endtask

  task automatic t_reload_running;
    int w;
    wr(2'd0, 8'd3);
    chk("R8", "stopped load 3", count_dbg, 3);
    wr(2'd1, 8'h01);
    w = edge_w;
    wr_at(w + 2, 2'd0, 8'd7);
    chk("R8", "running write keeps count", count_dbg, 3);
    goto(w + 11);
    chk("R8", "old period kept", irq, 0);
    goto(w + 12);
    chk("R8", "wrap at old period", irq, 1);
    chk("R5", "reload newest value", count_dbg, 7);
    wr_at(w + 14, 2'd2, 8'h01);
    chk("R6", "ack", irq, 0);
    goto(w + 39);
    chk("R8", "new period count", count_dbg, 1);
    chk("R8", "new period irq low", irq, 0);
    goto(w + 40);
    chk("R8", "new period wrap", irq, 1);
    wr_at(w + 42, 2'd1, 8'h00);
    repeat (50) @(negedge clk);
    chk("R9", "pending irq kept stopped", irq, 1);
    chk("R9", "count held", count_dbg, 7);
    wr(2'd2, 8'h01);
    chk("R6", "ack while stopped", irq, 0);
  endtask

  task automatic t_full_range;
    int w;
    wr(2'd0, 8'd0);
    wr(2'd1, 8'h01);
    w = edge_w;
    goto(w + 4);
    chk("R4", "zero steps to 255", count_dbg, 255);
    goto(w + 1023);
    chk("R4", "no irq before 256us", irq, 0);
    goto(w + 1024);
    chk("R4", "irq at 256us", irq, 1);
    chk("R5", "reload zero", count_dbg, 0);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h01);
  endtask

  task automatic t_set_wins;
    int w;
    wr(2'd0, 8'd1);
    wr(2'd1, 8'h01);
    w = edge_w;
    goto(w + 4);
    chk("R4", "period 1us", irq, 1);
    chk("R5", "count reloads to 1", count_dbg, 1);
    wr_at(w + 8, 2'd2, 8'h01);
    chk("R7", "set beats ack", irq, 1);
    wr_at(w + 10, 2'd2, 8'h01);
    chk("R7", "ack off-wrap clears", irq, 0);
    goto(w + 12);
    chk("R4", "next 1us wrap", irq, 1);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h01);
    chk("R6", "final ack", irq, 0);
  endtask

  task automatic run_all;
    t_reset();
    t_load_stopped();
    t_basic_period();
    t_reload_running();
    t_full_range();
    t_set_wins();
  endtask

  initial begin
    errors  = 0;
    checks  = 0;
    cyc     = 0;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = 2'd3;
    wr_data = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule